// File: doc/BRIEF.md
# SECDED Burst Read Checker

This block sits on the read return path from ECC-protected memory. Each burst beat arrives with its raw data word, its check bits, a beat strobe and a tag that marks read-modify-write traffic. Every beat is decoded with a single-error-correct, double-error-detect Hamming code. A single-bit error is repaired only while the correction enable is high. A double-bit error, or any pattern the code cannot place, passes through untouched and is flagged.

The decoder takes one beat per clock and has a fixed two-clock latency. Two per-burst vectors carry one bit per beat position, one for single-bit errors and one for uncorrectable errors. They accumulate across the burst, restart with its first beat, and read non-zero only while the user data-valid strobe is high. Beats tagged as read-modify-write never raise the user strobe. Their corrected data leaves on a separate strobe for the merge logic.

Top module: `secded_rd_path`

## Requirements
- R1: While reset is high and on the cycle after it, `out_vld`, `rmw_vld`, `sbe_vec` and `dbe_vec` are all zero.
- R2: A beat accepted on a clock edge (with `in_vld` high) appears on the outputs two edges later. Beats may arrive on consecutive cycles, and each produces exactly one output cycle, in order.
- R3: Check-bit encoding for P Hamming bits plus one overall parity bit (P=7, CHK_W=8 for 64-bit data). Data bit i sits at the i-th codeword position, counting upward from 3, that is not a power of two. Check bit j (j<P) is the XOR of the data bits whose position has bit j set. Check bit P is the XOR of all data bits and check bits 0..P-1. A beat that matches this encoding is output unchanged with no error flag.
- R4: With `corr_en` high during the beat, a single flipped data bit is corrected, and the beat's bit in `sbe_vec` is set.
- R5: With `corr_en` low during the beat, a single flipped data bit is still flagged in `sbe_vec`, but the output data equals the received data.
- R6: A single flipped check bit, including the overall parity bit, leaves the data unchanged and sets the beat's `sbe_vec` bit.
- R7: Two flipped bits in a beat set that beat's `dbe_vec` bit and leave its `sbe_vec` bit clear. The received data is output uncorrected.
- R8: Odd overall parity with a syndrome that names no codeword position (for example all P syndrome bits set with 64-bit data) is treated as uncorrectable. It sets `dbe_vec` and passes the data raw.
- R9: Beat position is counted over `in_vld` beats from reset, wrapping after BEATS beats; idle cycles between beats do not advance it. Bit b of each vector belongs to beat b of the burst.
- R10: Within a burst the vectors accumulate the flags of the beats seen so far. The first beat of a burst clears earlier flags. Both vectors are zero whenever `out_vld` is low.
- R11: A beat with `in_rmw` high raises `rmw_vld` instead of `out_vld`, with its data decoded as for a user beat and both vectors reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_en | input | 1 | Enables single-bit correction, sampled with the beat |
| in_vld | input | 1 | Beat strobe |
| in_rmw | input | 1 | Beat belongs to a read-modify-write read |
| in_data | input | DATA_W | Raw data word |
| in_chk | input | CHK_W | Raw check bits |
| out_vld | output | 1 | User data valid |
| rmw_vld | output | 1 | Data valid for the merge path |
| out_data | output | DATA_W | Decoded data |
| sbe_vec | output | BEATS | Single-bit error flag per beat |
| dbe_vec | output | BEATS | Uncorrectable error flag per beat |

## Verification
Clean bursts use zero, all-ones, alternating and counting data. They confirm the encoding and the two-cycle latency without any error flag. A mixed burst places single data-bit flips at both ends of the word, single check-bit flips (including the overall parity bit), a double flip and an unplaceable syndrome at known beat positions. This separates correction, check-bit-only errors and the two uncorrectable classes. It also shows each flag landing at its own vector bit. A burst with correction disabled and gaps between beats separates flagging from repair and confirms that idle cycles do not move the beat position. An errored RMW burst followed by a clean user burst shows the user strobe staying low and the vectors restarting.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Number of Hamming bits P is the smallest with 2^P >= DW+P+1; width adds the overall parity bit.
  function automatic int chk_width(input int dw);
    for (int p = 2; p < 32; p++) begin
      if ((1 << p) >= dw + p + 1) return p + 1;
    end
    return 32;
  endfunction

  // Codeword position of data bit idx: the idx-th non-power-of-two position from 3 upward.
  function automatic int data_pos(input int idx);
    int cnt;
    cnt = 0;
    for (int p = 3; p < 8192; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = secded_pkg::chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [CHK_W-2:0]  syn,
  output logic              par_odd
);
  localparam int P = CHK_W - 1;

  function automatic logic [DATA_W-1:0] col_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = ((secded_pkg::data_pos(i) >> j) & 1) == 1;
    end
    return m;
  endfunction

  for (genvar j = 0; j < P; j++) begin : g_syn
    localparam logic [DATA_W-1:0] MASK = col_mask(j);
    assign syn[j] = (^(data & MASK)) ^ chk[j];
  end

  // Odd parity over the whole received codeword means an odd number of flips.
  assign par_odd = (^data) ^ (^chk);

endmodule

// File: rtl/secded_fix.sv
module secded_fix #(
  parameter int DATA_W = 64,
  parameter int P      = 7
) (
  input  logic [DATA_W-1:0] data,
  input  logic [P-1:0]      syn,
  input  logic              par_odd,
  input  logic              fix_en,
  output logic [DATA_W-1:0] data_out,
  output logic              single_err,
  output logic              multi_err
);
  logic [DATA_W-1:0] hit;
  logic              syn_zero;
  logic              syn_chk;
  logic              placeable;

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    localparam int POS = secded_pkg::data_pos(i);
    assign hit[i] = (syn == P'(POS));
  end

  assign syn_zero  = (syn == '0);
  assign syn_chk   = ($countones(syn) == 1);
  assign placeable = syn_zero || syn_chk || (|hit);

  always_comb begin
    single_err = par_odd && placeable;
    multi_err  = (!par_odd && !syn_zero) || (par_odd && !placeable);
    data_out   = data;
    if (fix_en && par_odd) data_out = data ^ hit;
  end

endmodule

// File: rtl/secded_vec_acc.sv
module secded_vec_acc #(
  parameter int BEATS = 8,
  parameter int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_vld,
  input  logic             beat_user,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic             beat_sbe,
  input  logic             beat_dbe,
  output logic [BEATS-1:0] sbe_vec,
  output logic [BEATS-1:0] dbe_vec
);
  logic [BEATS-1:0] acc_s, acc_d;
  logic [BEATS-1:0] nxt_s, nxt_d;
  logic [BEATS-1:0] sel;

  always_comb begin
    sel   = '0;
    sel[beat_idx] = 1'b1;
    nxt_s = (beat_idx == '0) ? '0 : acc_s;
    nxt_d = (beat_idx == '0) ? '0 : acc_d;
    if (beat_sbe) nxt_s = nxt_s | sel;
    if (beat_dbe) nxt_d = nxt_d | sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_s   <= '0;
      acc_d   <= '0;
      sbe_vec <= '0;
      dbe_vec <= '0;
    end else begin
      if (beat_vld) begin
        acc_s <= nxt_s;
        acc_d <= nxt_d;
      end
      sbe_vec <= (beat_vld && beat_user) ? nxt_s : '0;
      dbe_vec <= (beat_vld && beat_user) ? nxt_d : '0;
    end
  end

endmodule

// File: rtl/secded_rd_path.sv
module secded_rd_path #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 8,
  parameter int CHK_W  = secded_pkg::chk_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              corr_en,
  input  logic              in_vld,
  input  logic              in_rmw,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHK_W-1:0]  in_chk,
  output logic              out_vld,
  output logic              rmw_vld,
  output logic [DATA_W-1:0] out_data,
  output logic [BEATS-1:0]  sbe_vec,
  output logic [BEATS-1:0]  dbe_vec
);
  localparam int P     = CHK_W - 1;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  // Input-side beat position
  logic [IDX_W-1:0] in_idx;
  always_ff @(posedge clk) begin
    if (rst)         in_idx <= '0;
    else if (in_vld) in_idx <= (in_idx == LAST) ? '0 : in_idx + 1'b1;
  end

  // Stage 1: syndrome
  logic [P-1:0]      syn_c;
  logic              par_c;
  logic              s1_vld, s1_rmw, s1_cen, s1_par;
  logic [IDX_W-1:0]  s1_idx;
  logic [DATA_W-1:0] s1_data;
  logic [P-1:0]      s1_syn;

  secded_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
    .data    (in_data),
    .chk     (in_chk),
    .syn     (syn_c),
    .par_odd (par_c)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_vld;
    s1_rmw  <= in_rmw;
    s1_cen  <= corr_en;
    s1_idx  <= in_idx;
    s1_data <= in_data;
    s1_syn  <= syn_c;
    s1_par  <= par_c;
  end

  // Stage 2: correction and classification
  logic [DATA_W-1:0] fix_data;
  logic              fix_sbe, fix_dbe;

  secded_fix #(.DATA_W(DATA_W), .P(P)) u_fix (
    .data       (s1_data),
    .syn        (s1_syn),
    .par_odd    (s1_par),
    .fix_en     (s1_cen),
    .data_out   (fix_data),
    .single_err (fix_sbe),
    .multi_err  (fix_dbe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      rmw_vld <= 1'b0;
    end else begin
      out_vld <= s1_vld && !s1_rmw;
      rmw_vld <= s1_vld && s1_rmw;
    end
    out_data <= fix_data;
  end

  secded_vec_acc #(.BEATS(BEATS), .IDX_W(IDX_W)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .beat_vld  (s1_vld),
    .beat_user (!s1_rmw),
    .beat_idx  (s1_idx),
    .beat_sbe  (fix_sbe),
    .beat_dbe  (fix_dbe),
    .sbe_vec   (sbe_vec),
    .dbe_vec   (dbe_vec)
  );

endmodule

// File: rtl/secded_rd_path_chk.sv
module secded_rd_path_chk #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              corr_en,
  input logic              in_vld,
  input logic              in_rmw,
  input logic [DATA_W-1:0] in_data,
  input logic              out_vld,
  input logic              rmw_vld,
  input logic [DATA_W-1:0] out_data,
  input logic [BEATS-1:0]  sbe_vec,
  input logic [BEATS-1:0]  dbe_vec
);
  // R2
  latency_user_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld && !in_rmw |=> ##1 out_vld);

  // R11
  latency_rmw_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld && in_rmw |=> ##1 (rmw_vld && !out_vld));

  // R10
  vec_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (sbe_vec == '0 && dbe_vec == '0));

  // R7
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (sbe_vec & dbe_vec) == '0);

  // R5
  raw_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld && !corr_en |=> ##1 (out_data == $past(in_data, 2)));

endmodule

bind secded_rd_path secded_rd_path_chk #(.DATA_W(DATA_W), .BEATS(BEATS)) u_chk (.*);

// File: tb/secded_rd_path_bench.sv
module secded_rd_path_bench;
  localparam int DW = 64;
  localparam int NB = 8;
  localparam int CW = 8;

  typedef enum int {K_NONE, K_D1, K_C1, K_D2, K_BAD} kind_t;
  typedef struct {
    logic          rmw;
    logic [DW-1:0] d;
    logic [NB-1:0] s;
    logic [NB-1:0] x;
    int            cyc;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic corr_en = 1'b1, in_vld = 1'b0, in_rmw = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_chk = '0;
  logic out_vld, rmw_vld;
  logic [DW-1:0] out_data;
  logic [NB-1:0] sbe_vec, dbe_vec;

  int cyc = 0, checks = 0, fails = 0;
  int m_idx = 0;
  logic [NB-1:0] m_s = '0, m_x = '0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  secded_rd_path u_secded_rd_path (
    .clk(clk), .rst(rst), .corr_en(corr_en), .in_vld(in_vld), .in_rmw(in_rmw),
    .in_data(in_data), .in_chk(in_chk), .out_vld(out_vld), .rmw_vld(rmw_vld),
    .out_data(out_data), .sbe_vec(sbe_vec), .dbe_vec(dbe_vec));

  function automatic int pos_of(input int idx);
    int c = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (c == idx) return p;
        c++;
      end
    end
    return 0;
  endfunction

  // R3 encoding
  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int j = 0; j < CW - 1; j++)
      for (int i = 0; i < DW; i++)
        if ((pos_of(i) >> j) & 1) c[j] = c[j] ^ d[i];
    c[CW-1] = (^d) ^ (^c[CW-2:0]);
    return c;
  endfunction

  task automatic send(input logic [DW-1:0] d, input kind_t k, input int a, input int b,
                      input logic rmw, input logic cen, input string tag);
    logic [CW-1:0] c;
    logic [DW-1:0] raw;
    exp_t e;
    logic fs, fx;
    c = encode(d);
    raw = d;
    fs = 1'b0;
    fx = 1'b0;
    case (k)
      K_D1:  begin raw[a] = ~raw[a]; fs = 1'b1; end
      K_C1:  begin c[a] = ~c[a]; fs = 1'b1; end
      K_D2:  begin raw[a] = ~raw[a]; raw[b] = ~raw[b]; fx = 1'b1; end
      K_BAD: begin c[CW-2:0] = c[CW-2:0] ^ 7'h7F; fx = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    in_vld = 1'b1; in_rmw = rmw; corr_en = cen; in_data = raw; in_chk = c;
    if (m_idx == 0) begin m_s = '0; m_x = '0; end
    m_s[m_idx] = fs;
    m_x[m_idx] = fx;
    e.rmw = rmw;
    e.d   = (k == K_D1 && cen) ? d : raw;
    e.s   = rmw ? '0 : m_s;
    e.x   = rmw ? '0 : m_x;
    e.cyc = cyc;
    e.tag = tag;
    q.push_back(e);
    m_idx = (m_idx == NB - 1) ? 0 : m_idx + 1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_vld = 1'b0;
    if (n > 1) repeat (n - 1) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_vld || rmw_vld) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected output: out_vld=%0b rmw_vld=%0b expected none", out_vld, rmw_vld);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_vld !== !e.rmw || rmw_vld !== e.rmw || cyc != e.cyc + 2 ||
              out_data !== e.d || sbe_vec !== e.s || dbe_vec !== e.x) begin
            fails++;
            $display("FAIL %s: vld=%0b rmw=%0b cyc=%0d d=%h s=%b x=%b expected vld=%0b rmw=%0b cyc=%0d d=%h s=%b x=%b",
              e.tag, out_vld, rmw_vld, cyc, out_data, sbe_vec, dbe_vec,
              !e.rmw, e.rmw, e.cyc + 2, e.d, e.s, e.x);
          end
        end
      end else begin
        // R10 vectors zero while no user beat
        checks++;
        if (sbe_vec !== '0 || dbe_vec !== '0) begin
          fails++;
          $display("FAIL R10 idle vectors: s=%b x=%b expected 0 0", sbe_vec, dbe_vec);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_vld !== 1'b0 || rmw_vld !== 1'b0 || sbe_vec !== '0 || dbe_vec !== '0) begin
      fails++;
      $display("FAIL R1 reset: vld=%0b rmw=%0b s=%b x=%b expected 0 0 0 0", out_vld, rmw_vld, sbe_vec, dbe_vec);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || rmw_vld !== 1'b0 || sbe_vec !== '0 || dbe_vec !== '0) begin
      fails++;
      $display("FAIL R1 after reset: vld=%0b rmw=%0b s=%b x=%b expected 0 0 0 0", out_vld, rmw_vld, sbe_vec, dbe_vec);
    end

    // R3 / R2: clean back-to-back burst
    send('0, K_NONE, 0, 0, 1'b0, 1'b1, "R3 zero");
    send('1, K_NONE, 0, 0, 1'b0, 1'b1, "R3 ones");
    send({16{4'hA}}, K_NONE, 0, 0, 1'b0, 1'b1, "R3 alt");
    send({16{4'h5}}, K_NONE, 0, 0, 1'b0, 1'b1, "R3 alt5");
    for (int i = 0; i < 4; i++)
      send(64'h0123_4567_89AB_CDEF + 64'(i * 64'h1111), K_NONE, 0, 0, 1'b0, 1'b1, "R2 count");
    idle(3);

    // Mixed error burst: R4 R6 R7 R8 R9
    send(64'hDEAD_BEEF_0000_FFFF, K_NONE, 0, 0, 1'b0, 1'b1, "R9 beat0");
    send(64'hDEAD_BEEF_0000_FFFF, K_D1, 0, 0, 1'b0, 1'b1, "R4 bit0");
    send(64'h1357_9BDF_2468_ACE0, K_D1, 63, 0, 1'b0, 1'b1, "R4 bit63");
    send(64'hCAFE_F00D_1234_5678, K_C1, 2, 0, 1'b0, 1'b1, "R6 chk2");
    send(64'hCAFE_F00D_1234_5678, K_C1, 7, 0, 1'b0, 1'b1, "R6 overall");
    send(64'h0F0F_0F0F_F0F0_F0F0, K_D2, 5, 40, 1'b0, 1'b1, "R7 double");
    send(64'h7777_8888_9999_AAAA, K_BAD, 0, 0, 1'b0, 1'b1, "R8 unplaceable");
    send(64'h0000_0001_0000_0000, K_NONE, 0, 0, 1'b0, 1'b1, "R9 beat7");
    idle(2);

    // R5 correction off, gaps between beats (R9)
    for (int i = 0; i < NB; i++) begin
      send(64'hA5A5_5A5A_0000_0000 + 64'(i), K_D1, i * 9, 0, 1'b0, 1'b0, "R5 no-correct");
      if (i % 3 == 1) idle(2);
    end
    idle(2);

    // R11 RMW burst with errors
    for (int i = 0; i < NB; i++)
      send(64'hFEED_0000_0000_0000 | 64'(i << 4), (i % 2 == 1) ? K_D1 : K_D2, i + 3, i + 20,
           1'b1, 1'b1, "R11 rmw");
    idle(2);

    // R10 clean burst clears vectors
    for (int i = 0; i < NB; i++)
      send(64'(i) * 64'h0101_0101_0101_0101, (i == 4) ? K_C1 : K_NONE, 0, 0, 1'b0, 1'b1, "R10 restart");
    idle(6);

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 outstanding beats: %0d expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule